// File: doc/BRIEF.md
# Outbound Address Translation Window Unit

This block maps addresses from a local bus into a 64-bit outbound memory space. The outbound region begins at a fixed local base address. It is cut into 32 windows of equal size, and the window size is set at run time to 2^k megabytes, where k is a 3-bit value. Each window holds two offset words. The low word carries the upper address bits and, in bit 0, a valid flag. The high word supplies the upper 32 bits of the outbound address.

A request enters as a local address with a valid strobe. One clock later the block returns either the translated 64-bit address or a miss flag. It picks the window from the address bits above the window size and substitutes that window's programmed offset for them. The bits below the window size pass through unchanged. A global enable gates all translation.

Configuration is write-only, through a simple word-addressed port. The outbound data path, the transaction layer and ordering are handled elsewhere.

Top module: `ob_window_xlate`

## Requirements
- R1: After reset, the global enable is off, every window is invalid and the size index is 0, so every request returns respMiss=1.
- R2: Every request accepted with reqValid=1 produces exactly one result, with respValid=1, on the following clock. No result appears without a request.
- R3: Bit 1 of the control word at configuration offset 0x004 is the global translation enable. The other bits of that word are ignored. While the enable is 0, every request misses.
- R4: The size word at offset 0x030 keeps only its low 3 bits, k. The window size is 2^(20+k) bytes. The window index is (reqAddr - REGION_BASE) >> (20+k).
- R5: For window n (0..31), the low offset word is at offset 0x200+8n and the high offset word is at 0x204+8n.
- R6: A window whose low-word bit 0 is 0 is invalid, and any request that selects it misses.
- R7: On a hit, respAddr = {high word, low word with bits below 20+k cleared} OR ((reqAddr - REGION_BASE) with only bits below 20+k kept).
- R8: An address below REGION_BASE, or one whose window index is 32 or more, misses.
- R9: A configuration write takes effect for requests presented on the next clock and later. A request on the same clock as the write uses the old settings.
- R10: A miss result carries respAddr = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 12 | Configuration byte offset |
| cfgWrData | input | 32 | Configuration write data |
| reqValid | input | 1 | Request strobe |
| reqAddr | input | 32 | Local address to translate |
| respValid | output | 1 | Result valid, one clock after the request |
| respMiss | output | 1 | Result is a miss |
| respAddr | output | 64 | Translated outbound address, 0 on a miss |

## Verification
The bound checker watches several properties on every cycle. It checks the one-clock request-to-result pairing and the zero address on a miss. It checks that a request below the base, or any request while a shadow copy of the enable bit is clear, misses. It also checks that a hit keeps the low 20 address bits. The bench scenarios are needed for the rest: whether the right window is chosen as the size index moves, the exact substituted upper bits, the end windows 0 and 31, the region end, and the same-clock ordering of a write against a request.

// File: rtl/obx_pkg.sv
package obx_pkg;
  localparam int OBX_NUM_WIN = 32;
  localparam int OBX_WIN_W   = $clog2(OBX_NUM_WIN);
  localparam int OBX_DATA_W  = 32;

  typedef struct packed {
    logic                  enWe;
    logic                  sizeWe;
    logic                  loWe;
    logic                  hiWe;
    logic [OBX_WIN_W-1:0]  win;
    logic [OBX_DATA_W-1:0] data;
  } obxStrobe_t;
endpackage

// File: rtl/obx_ctrl.sv
module obx_ctrl
  import obx_pkg::*;
#(
  parameter int CFG_AW = 12,
  parameter logic [CFG_AW-1:0] CTRL_OFS = 12'h004,
  parameter logic [CFG_AW-1:0] SIZE_OFS = 12'h030,
  parameter logic [CFG_AW-1:0] WIN_OFS  = 12'h200
) (
  input  logic                  cfgWrEn,
  input  logic [CFG_AW-1:0]     cfgAddr,
  input  logic [OBX_DATA_W-1:0] cfgWrData,
  output obxStrobe_t            stb
);
  localparam int WIN_SPAN = OBX_NUM_WIN * 8;

  logic [CFG_AW-1:0] relOfs;
  logic inWin;

  assign relOfs = cfgAddr - WIN_OFS;
  assign inWin  = (cfgAddr >= WIN_OFS) && (relOfs < CFG_AW'(WIN_SPAN));

  always_comb begin
    stb        = '0;
    stb.data   = cfgWrData;
    stb.win    = relOfs[3 +: OBX_WIN_W];
    stb.enWe   = cfgWrEn && (cfgAddr == CTRL_OFS);
    stb.sizeWe = cfgWrEn && (cfgAddr == SIZE_OFS);
    stb.loWe   = cfgWrEn && inWin && (relOfs[2:0] == 3'd0);
    stb.hiWe   = cfgWrEn && inWin && (relOfs[2:0] == 3'd4);
  end
endmodule

// File: rtl/obx_datapath.sv
module obx_datapath
  import obx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 3,
  parameter int MB_SHIFT = 20,
  parameter int EN_BIT = 1,
  parameter logic [ADDR_W-1:0] REGION_BASE = 32'h4000_0000
) (
  input  logic                clk,
  input  logic                rstN,
  input  obxStrobe_t          stb,
  input  logic                reqValid,
  input  logic [ADDR_W-1:0]   reqAddr,
  output logic                respValid,
  output logic                respMiss,
  output logic [2*ADDR_W-1:0] respAddr
);
  localparam int SH_W = 6;

  logic              xlateEn;
  logic [SIZE_W-1:0] sizeIdx;
  logic [ADDR_W-1:0] winLo [OBX_NUM_WIN];
  logic [ADDR_W-1:0] winHi [OBX_NUM_WIN];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xlateEn <= 1'b0;
      sizeIdx <= '0;
      for (int i = 0; i < OBX_NUM_WIN; i++) begin
        winLo[i] <= '0;
        winHi[i] <= '0;
      end
    end else begin
      if (stb.enWe)   xlateEn <= stb.data[EN_BIT];
      if (stb.sizeWe) sizeIdx <= stb.data[SIZE_W-1:0];
      if (stb.loWe)   winLo[stb.win] <= stb.data;
      if (stb.hiWe)   winHi[stb.win] <= stb.data;
    end
  end

  logic [SH_W-1:0]      shAmt;
  logic [ADDR_W-1:0]    offs, subMask, idxFull, loSel;
  logic [OBX_WIN_W-1:0] win;
  logic                 inRegion, hit;
  logic [2*ADDR_W-1:0]  xlated;

  always_comb begin
    shAmt    = SH_W'(MB_SHIFT) + SH_W'(sizeIdx);
    offs     = reqAddr - REGION_BASE;
    subMask  = (ADDR_W'(1) << shAmt) - ADDR_W'(1);
    idxFull  = offs >> shAmt;
    inRegion = (reqAddr >= REGION_BASE) && (idxFull < ADDR_W'(OBX_NUM_WIN));
    win      = idxFull[OBX_WIN_W-1:0];
    loSel    = winLo[win];
    hit      = xlateEn && inRegion && loSel[0];
    xlated   = {winHi[win], (loSel & ~subMask) | (offs & subMask)};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respMiss  <= 1'b0;
      respAddr  <= '0;
    end else begin
      respValid <= reqValid;
      respMiss  <= reqValid && !hit;
      respAddr  <= (reqValid && hit) ? xlated : '0;
    end
  end
endmodule

// File: rtl/ob_window_xlate.sv
module ob_window_xlate
  import obx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CFG_AW = 12,
  parameter logic [ADDR_W-1:0] REGION_BASE = 32'h4000_0000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWrEn,
  input  logic [CFG_AW-1:0]     cfgAddr,
  input  logic [OBX_DATA_W-1:0] cfgWrData,
  input  logic                  reqValid,
  input  logic [ADDR_W-1:0]     reqAddr,
  output logic                  respValid,
  output logic                  respMiss,
  output logic [2*ADDR_W-1:0]   respAddr
);
  obxStrobe_t stb;

  obx_ctrl #(.CFG_AW(CFG_AW)) u_ctrl (
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData), .stb(stb)
  );

  obx_datapath #(.ADDR_W(ADDR_W), .REGION_BASE(REGION_BASE)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqValid(reqValid), .reqAddr(reqAddr),
    .respValid(respValid), .respMiss(respMiss), .respAddr(respAddr)
  );
endmodule

// File: rtl/obx_checker.sv
module obx_checker #(
  parameter int ADDR_W = 32,
  parameter int CFG_AW = 12,
  parameter logic [ADDR_W-1:0] REGION_BASE = 32'h4000_0000
) (
  input logic                clk,
  input logic                rstN,
  input logic                cfgWrEn,
  input logic [CFG_AW-1:0]   cfgAddr,
  input logic [31:0]         cfgWrData,
  input logic                reqValid,
  input logic [ADDR_W-1:0]   reqAddr,
  input logic                respValid,
  input logic                respMiss,
  input logic [2*ADDR_W-1:0] respAddr
);
  logic shadowEn;
  always_ff @(posedge clk) begin
    if (!rstN) shadowEn <= 1'b0;
    else if (cfgWrEn && cfgAddr == CFG_AW'(12'h004))
      shadowEn <= (cfgWrData & 32'h2) != 32'h0;
  end

  AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid); // R2
  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !respValid); // R2
  AST_DISABLED_MISSES: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !shadowEn) |=> respMiss); // R3
  AST_BELOW_BASE_MISSES: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAddr < REGION_BASE) |=> respMiss); // R8
  AST_MISS_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respMiss) |-> (respAddr == '0)); // R10
  AST_HIT_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (respMiss || respAddr[19:0] == $past(reqAddr[19:0]))); // R7
endmodule

bind ob_window_xlate obx_checker #(.ADDR_W(ADDR_W), .CFG_AW(CFG_AW), .REGION_BASE(REGION_BASE)) u_chk (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
  .reqValid(reqValid), .reqAddr(reqAddr), .respValid(respValid), .respMiss(respMiss),
  .respAddr(respAddr)
);

// File: tb/ob_window_xlate_tb.sv
module ob_window_xlate_tb;
  localparam logic [31:0] BASE = 32'h4000_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [11:0] cfgAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic respValid, respMiss;
  logic [63:0] respAddr;

  always #10 clk = ~clk;

  ob_window_xlate u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .reqValid(reqValid), .reqAddr(reqAddr), .respValid(respValid), .respMiss(respMiss),
    .respAddr(respAddr)
  );

  typedef struct { logic miss; logic [63:0] addr; string tag; } exp_t;
  exp_t expQ[$];
  int nChecks = 0, nFails = 0;
  bit done = 0;

  logic [31:0] mLo [32];
  logic [31:0] mHi [32];
  logic [2:0]  mSize = 3'd0;
  logic        mEn = 1'b0;

  initial for (int i = 0; i < 32; i++) begin mLo[i] = '0; mHi[i] = '0; end

  function automatic exp_t model(input logic [31:0] a, input string tag);
    exp_t e;
    logic [31:0] off, msk, idx;
    int sh;
    sh  = 20 + int'(mSize);
    off = a - BASE;
    msk = (32'd1 << sh) - 32'd1;
    idx = off >> sh;
    e.tag = tag;
    if (!mEn || a < BASE || idx >= 32 || !mLo[idx[4:0]][0]) begin
      e.miss = 1'b1; e.addr = '0;
    end else begin
      e.miss = 1'b0;
      e.addr = {mHi[idx[4:0]], (mLo[idx[4:0]] & ~msk) | (off & msk)};
    end
    return e;
  endfunction

  task automatic modelWrite(input logic [11:0] a, input logic [31:0] d);
    if (a == 12'h004) mEn = d[1];
    else if (a == 12'h030) mSize = d[2:0];
    else if (a >= 12'h200 && a < 12'h300) begin
      if (a[2:0] == 3'd0) mLo[(a - 12'h200) >> 3] = d;
      else if (a[2:0] == 3'd4) mHi[(a - 12'h200) >> 3] = d;
    end
  endtask

  task automatic cfgWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d; reqValid = 1'b0;
    modelWrite(a, d);
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  // driver: pushes the expected result, drives one request
  task automatic request(input logic [31:0] a, input string tag);
    @(negedge clk);
    cfgWrEn = 1'b0;
    reqValid = 1'b1; reqAddr = a;
    expQ.push_back(model(a, tag));
  endtask

  task automatic idle();
    @(negedge clk);
    reqValid = 1'b0; cfgWrEn = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN && respValid) begin
      exp_t e;
      nChecks++;
      if (expQ.size() == 0) begin
        nFails++;
        $display("FAIL R2 unexpected result: actual valid=1 expected none");
      end else begin
        e = expQ.pop_front();
        if (respMiss !== e.miss || respAddr !== e.addr) begin
          nFails++;
          $display("FAIL %s: actual miss=%0b addr=%h expected miss=%0b addr=%h",
                   e.tag, respMiss, respAddr, e.miss, e.addr);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL R2 watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    nChecks++;
    if (respValid !== 1'b0 || respAddr !== 64'h0) begin
      nFails++;
      $display("FAIL R1 reset outputs: actual valid=%0b addr=%h expected 0", respValid, respAddr);
    end
    rstN = 1'b1;

    // R1: reset state misses everywhere
    request(BASE, "R1 post-reset");
    request(BASE + 32'h0012_3456, "R1 post-reset");
    idle();

    // R5 windows, R3 enable with stray bits
    cfgWrite(12'h200, 32'h8000_0001);
    cfgWrite(12'h204, 32'h0000_0001);
    cfgWrite(12'h218, 32'h1234_5671);
    cfgWrite(12'h21C, 32'h0000_00AB);
    request(BASE + 32'h0001_2345, "R3 enable still off");
    cfgWrite(12'h004, 32'hFFFF_FFF2);
    request(BASE + 32'h0001_2345, "R7 window 0 hit");
    request(BASE + 32'h0030_0FF0, "R5 window 3 hit");
    request(BASE + 32'h0010_0000, "R6 invalid window 1");
    idle();

    // R4: size index with ignored upper bits
    cfgWrite(12'h030, 32'hFFFF_FFFA);
    request(BASE + 32'h00C0_1234, "R4 size 4MB window 3");
    request(BASE + 32'h003F_FFFF, "R4 size 4MB window 0 top");
    cfgWrite(12'h2F8, 32'h7700_0001);
    cfgWrite(12'h2FC, 32'hDEAD_BEEF);
    request(BASE + 32'h07FF_FFFF, "R8 window 31 last byte");
    request(BASE + 32'h0800_0000, "R8 past region end");
    request(BASE - 32'd4, "R8 below base");
    idle();

    // R3: global disable
    cfgWrite(12'h004, 32'h0000_0001);
    request(BASE + 32'h0000_0010, "R3 disabled");
    cfgWrite(12'h004, 32'h0000_0002);
    request(BASE + 32'h0000_0010, "R3 re-enabled");
    idle();

    // R9: write and request on the same clock
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = 12'h228; cfgWrData = 32'h5500_0001;
    reqValid = 1'b1; reqAddr = BASE + 32'h0140_0004;
    expQ.push_back(model(BASE + 32'h0140_0004, "R9 same-clock old value"));
    modelWrite(12'h228, 32'h5500_0001);
    @(negedge clk);
    cfgWrEn = 1'b0;
    reqAddr = BASE + 32'h0140_0004;
    expQ.push_back(model(BASE + 32'h0140_0004, "R9 next-clock new value"));
    idle();

    // R4: largest size
    cfgWrite(12'h030, 32'h0000_0007);
    request(BASE + 32'h0812_3456, "R4 size 128MB window 1 invalid");
    request(BASE + 32'h0012_3456, "R4 size 128MB window 0");
    request(BASE + 32'h1ABC_DEF0, "R4 size 128MB window 3");
    idle();
    repeat (3) idle();

    nChecks++;
    if (expQ.size() != 0) begin
      nFails++;
      $display("FAIL R2 pending results: actual %0d expected 0", expQ.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule